// File: doc/BRIEF.md
# Microstep Translator with Decay Selection

This block converts step and direction commands into current set-points for the two windings of a bipolar stepper motor. It keeps an electrical position of 32 eighth-step units per cycle. From that position it drives, for each winding, a 7-bit magnitude code for a current DAC, a polarity bit and a decay-mode code for the bridge regulator. A two-bit resolution input picks full, half, quarter or eighth stepping. That input is read only when a step edge arrives, so it can change freely between steps.

Every step also sets the decay mode of each winding. If a winding's new magnitude is below its previous magnitude, the winding takes the decay mode requested on a two-bit decay-select input. If the new magnitude is equal or higher, the winding uses slow decay. Three conditions return the position to the 45-degree home point and force mixed decay on both windings: a home command, sleep and undervoltage. While any of them holds, step edges are ignored. The output enable affects only the bridge-enable output. The translator keeps running whatever its state.

Top module: `stepper_xlate`

## Requirements
- R1: After `rst_n` is released the block is at home: `position` = 4, both magnitudes = 90, both polarity bits = 1, both decay codes = 2'b01 (mixed).
- R2: Each rising edge of `step_in` moves `position` by the increment of `res_sel`: 8 for 2'b00 (full), 4 for 2'b01 (half), 2 for 2'b10 (quarter), 1 for 2'b11 (eighth). The move is up when `dir_in`=1 and down when `dir_in`=0, modulo 32. The step edge is first seen at a clock edge, and the outputs change just after that clock edge.
- R3: After a step the new position is forced onto the grid of the mode used for that step. Full mode sets the low three bits to 3'b100. Half mode clears the low two bits. Quarter mode clears bit 0. The increment is added first, and the truncation follows.
- R4: `res_sel` is read only at a step edge. A change to `res_sel` without a step leaves every output unchanged.
- R5: Level index i (0..8) maps to magnitude code 0, 25, 49, 71, 90, 106, 117, 125, 127. Let k = position[2:0]. Phase A uses index k when position[3]=0 and index 8-k otherwise. Phase B uses index 8 minus the phase A index.
- R6: `pol_a` is 1 when position < 16. `pol_b` is 1 when position < 8 or position >= 24.
- R7: On a step, each phase whose new magnitude is below its old magnitude takes its decay code from `decay_sel`: 2'b00 gives slow (2'b00), 2'b01 gives mixed (2'b01), 2'b10 gives fast (2'b10), and 2'b11 gives mixed (2'b01). Every other phase gets slow (2'b00).
- R8: While `home_n`=0, `sleep_n`=0 or `uvlo`=1, the position is held at 4 and both decay codes at 2'b01, and step edges are ignored. A `step_in` that is still high when the hold ends does not cause a step.
- R9: `bridge_on` is 1 only when `en_n`=0, `home_n`=1, `sleep_n`=1 and `uvlo`=0.
- R10: Steps advance the position in the same way whether `en_n` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| home_n | input | 1 | Home command, active low; also turns the bridges off |
| sleep_n | input | 1 | Sleep, active low |
| uvlo | input | 1 | Undervoltage lockout, active high |
| en_n | input | 1 | Bridge output enable, active low |
| step_in | input | 1 | Step command; a rising edge advances the position |
| dir_in | input | 1 | Direction: 1 up, 0 down |
| res_sel | input | 2 | Step resolution code |
| decay_sel | input | 2 | Requested decay mode for falling current |
| mag_a | output | 7 | Phase A DAC magnitude code |
| pol_a | output | 1 | Phase A polarity, 1 positive |
| decay_a | output | 2 | Phase A decay mode code |
| mag_b | output | 7 | Phase B DAC magnitude code |
| pol_b | output | 1 | Phase B polarity, 1 positive |
| decay_b | output | 2 | Phase B decay mode code |
| bridge_on | output | 1 | Bridges may drive |
| position | output | 5 | Electrical position in eighth-step units |

## Verification
The bench runs full electrical cycles in every resolution, in both directions. Each cycle crosses the 31-to-0 wrap. A design that forgot the modulo, or swapped the cosine index, would show a wrong magnitude or polarity at a quadrant boundary. Switching from eighth to full mode at an odd position tests the grid truncation, where a design that skipped the alignment would leave the motor off its full-step points. Steps are made with each of the four `decay_sel` codes, and the code 2'b11 must become mixed and not pass through unchanged. Each hold source is exercised with a step held high across its release, which a design that did not track the step input during the hold would turn into a spurious step.

// File: rtl/stepper_xlate.sv
module stepper_xlate #(
  parameter int MAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             home_n,
  input  logic             sleep_n,
  input  logic             uvlo,
  input  logic             en_n,
  input  logic             step_in,
  input  logic             dir_in,
  input  logic [1:0]       res_sel,
  input  logic [1:0]       decay_sel,
  output logic [MAG_W-1:0] mag_a,
  output logic             pol_a,
  output logic [1:0]       decay_a,
  output logic [MAG_W-1:0] mag_b,
  output logic             pol_b,
  output logic [1:0]       decay_b,
  output logic             bridge_on,
  output logic [4:0]       position
);
  localparam int QSTEPS = 8;
  localparam int LUT_N  = 16;
  localparam logic [4:0] HOME = 5'd4;
  localparam logic [1:0] DK_SLOW = 2'b00, DK_MIX = 2'b01, DK_FAST = 2'b10;

  function automatic int sin_q15(input int i);
    case (i)
      0: return 0;
      1: return 6393;
      2: return 12540;
      3: return 18205;
      4: return 23170;
      5: return 27246;
      6: return 30274;
      7: return 32138;
      default: return 32768;
    endcase
  endfunction

  function automatic logic [MAG_W-1:0] to_code(input int i);
    longint v;
    v = (longint'(sin_q15(i)) * ((longint'(1) << MAG_W) - 1) + 16384) >>> 15;
    return v[MAG_W-1:0];
  endfunction

  function automatic logic [3:0] idx_a(input logic [4:0] p);
    return p[3] ? (4'd8 - {1'b0, p[2:0]}) : {1'b0, p[2:0]};
  endfunction

  logic [MAG_W-1:0] lvl [LUT_N];
  for (genvar g = 0; g < LUT_N; g++) begin : g_lvl
    if (g <= QSTEPS) begin : g_on
      assign lvl[g] = to_code(g);
    end else begin : g_off
      assign lvl[g] = '0;
    end
  end

  logic [4:0] pos, raw, nxt, inc;
  logic [1:0] dk_a, dk_b, req_dk;
  logic       step_q, edge_s, hold;
  logic [MAG_W-1:0] nmag_a, nmag_b;

  assign hold   = !home_n || !sleep_n || uvlo;
  assign edge_s = step_in && !step_q;
  assign inc    = 5'd8 >> res_sel;
  assign raw    = dir_in ? pos + inc : pos - inc;

  always_comb begin
    case (res_sel)
      2'b00:   nxt = {raw[4:3], 3'b100};
      2'b01:   nxt = {raw[4:2], 2'b00};
      2'b10:   nxt = {raw[4:1], 1'b0};
      default: nxt = raw;
    endcase
  end

  assign req_dk = (decay_sel == 2'b00) ? DK_SLOW :
                  (decay_sel == 2'b10) ? DK_FAST : DK_MIX;

  assign nmag_a = lvl[idx_a(nxt)];
  assign nmag_b = lvl[4'd8 - idx_a(nxt)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= HOME;
      dk_a   <= DK_MIX;
      dk_b   <= DK_MIX;
      step_q <= 1'b1;
    end else begin
      step_q <= step_in;
      if (hold) begin
        pos  <= HOME;
        dk_a <= DK_MIX;
        dk_b <= DK_MIX;
      end else if (edge_s) begin
        pos  <= nxt;
        dk_a <= (nmag_a < mag_a) ? req_dk : DK_SLOW;
        dk_b <= (nmag_b < mag_b) ? req_dk : DK_SLOW;
      end
    end
  end

  assign mag_a     = lvl[idx_a(pos)];
  assign mag_b     = lvl[4'd8 - idx_a(pos)];
  assign pol_a     = !pos[4];
  assign pol_b     = !(pos[4] ^ pos[3]);
  assign decay_a   = dk_a;
  assign decay_b   = dk_b;
  assign position  = pos;
  assign bridge_on = !en_n && !hold;
endmodule

// File: rtl/stepper_xlate_chk.sv
module stepper_xlate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       home_n,
  input logic       sleep_n,
  input logic       uvlo,
  input logic       step_in,
  input logic [1:0] res_sel,
  input logic [6:0] mag_a,
  input logic [6:0] mag_b,
  input logic [1:0] decay_a,
  input logic [1:0] decay_b,
  input logic [4:0] position
);
  logic st_q;
  logic act, edg;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= 1'b1;
    else        st_q <= step_in;
  assign act = home_n && sleep_n && !uvlo;
  assign edg = step_in && !st_q;

  // R8
  hold_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act) |=> (position == 5'd4 && decay_a == 2'b01 && decay_b == 2'b01));

  // R4
  no_step_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !edg) |=> ($stable(position) && $stable(decay_a) && $stable(decay_b)));

  // R3
  full_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && edg && res_sel == 2'b00) |=> (position[2:0] == 3'b100));

  // R7
  rise_slow_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && edg) |=> (mag_a < $past(mag_a) || decay_a == 2'b00));

  // R7
  rise_slow_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && edg) |=> (mag_b < $past(mag_b) || decay_b == 2'b00));

  // R7
  decay_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decay_a != 2'b11 && decay_b != 2'b11));

  // R5
  never_both_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_a != 7'd0 || mag_b != 7'd0));
endmodule

bind stepper_xlate stepper_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .home_n(home_n), .sleep_n(sleep_n), .uvlo(uvlo),
  .step_in(step_in), .res_sel(res_sel), .mag_a(mag_a), .mag_b(mag_b),
  .decay_a(decay_a), .decay_b(decay_b), .position(position)
);

// File: tb/sim_stepper_xlate.sv
`timescale 1ns/1ps
module sim_stepper_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0, home_n = 1'b1, sleep_n = 1'b1, uvlo = 1'b0, en_n = 1'b0;
  logic step_in = 1'b0, dir_in = 1'b1;
  logic [1:0] res_sel = 2'b11, decay_sel = 2'b01;
  logic [6:0] mag_a, mag_b;
  logic pol_a, pol_b, bridge_on;
  logic [1:0] decay_a, decay_b;
  logic [4:0] position;

  int checks = 0, errors = 0;
  int exp_pos = 4, exp_da = 1, exp_db = 1;
  int code_tbl [9] = '{0, 25, 49, 71, 90, 106, 117, 125, 127};

  always #4 clk = ~clk;

  stepper_xlate u0 (
    .clk(clk), .rst_n(rst_n), .home_n(home_n), .sleep_n(sleep_n), .uvlo(uvlo),
    .en_n(en_n), .step_in(step_in), .dir_in(dir_in), .res_sel(res_sel),
    .decay_sel(decay_sel), .mag_a(mag_a), .pol_a(pol_a), .decay_a(decay_a),
    .mag_b(mag_b), .pol_b(pol_b), .decay_b(decay_b), .bridge_on(bridge_on),
    .position(position)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ia(input int p);
    int k = p % 8;
    return ((p / 8) % 2 == 0) ? k : 8 - k;
  endfunction
  function automatic int ma(input int p); return code_tbl[ia(p)]; endfunction
  function automatic int mb(input int p); return code_tbl[8 - ia(p)]; endfunction

  task automatic chk_all(input string req);
    chk(req, "position", position, exp_pos);
    chk(req, "mag_a", mag_a, ma(exp_pos));
    chk(req, "mag_b", mag_b, mb(exp_pos));
    chk(req, "pol_a", pol_a, (exp_pos < 16) ? 1 : 0);
    chk(req, "pol_b", pol_b, (exp_pos < 8 || exp_pos >= 24) ? 1 : 0);
    chk(req, "decay_a", decay_a, exp_da);
    chk(req, "decay_b", decay_b, exp_db);
  endtask

  function automatic int map_dk(input int s);
    return (s == 0) ? 0 : (s == 2) ? 2 : 1;
  endfunction

  task automatic model_step(input int d, input int r);
    int inc = 8 >> r;
    int np = d ? (exp_pos + inc) % 32 : (exp_pos - inc + 32) % 32;
    if (r == 0) np = (np / 8) * 8 + 4;
    else if (r == 1) np = (np / 4) * 4;
    else if (r == 2) np = (np / 2) * 2;
    exp_da = (ma(np) < ma(exp_pos)) ? map_dk(decay_sel) : 0;
    exp_db = (mb(np) < mb(exp_pos)) ? map_dk(decay_sel) : 0;
    exp_pos = np;
  endtask

  task automatic do_step(input logic d, input logic [1:0] r);
    @(negedge clk);
    dir_in = d; res_sel = r; step_in = 1'b1;
    @(negedge clk);
    step_in = 1'b0;
    model_step(d, r);
  endtask

  // R1
  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_pos = 4; exp_da = 1; exp_db = 1;
    chk_all("R1");
    chk("R1", "mag_a home code", mag_a, 90);
    chk("R9", "bridge_on idle", bridge_on, 1);
  endtask

  // R2 R3 R5 R6 R7 sweep a full cycle and beyond
  task automatic t_sweep(input logic d, input logic [1:0] r, input logic [1:0] ds);
    int n = (32 >> (3 - r)) + 2;
    decay_sel = ds;
    for (int i = 0; i < n; i++) begin
      do_step(d, r);
      chk_all("R2_R5_R6_R7");
    end
  endtask

  // R4
  task automatic t_mode_hold();
    int p0 = exp_pos;
    @(negedge clk); res_sel = 2'b00;
    repeat (3) @(negedge clk);
    res_sel = 2'b01;
    repeat (2) @(negedge clk);
    chk("R4", "position after res change", position, p0);
    chk_all("R4");
    do_step(1'b1, 2'b11);
    chk_all("R4");
  endtask

  // R3
  task automatic t_align();
    decay_sel = 2'b10;
    do_step(1'b1, 2'b11);
    if (exp_pos % 2 == 0) do_step(1'b1, 2'b11);
    do_step(1'b1, 2'b00);
    chk("R3", "full grid low bits", position % 8, 4);
    chk_all("R3");
    do_step(1'b0, 2'b11);
    do_step(1'b0, 2'b01);
    chk("R3", "half grid low bits", position % 4, 0);
    do_step(1'b1, 2'b11);
    do_step(1'b0, 2'b10);
    chk("R3", "quarter grid bit0", position % 2, 0);
    chk_all("R3");
  endtask

  // R8 source: 0 home, 1 sleep, 2 uvlo
  task automatic t_hold(input int src);
    do_step(1'b1, 2'b11);
    do_step(1'b1, 2'b11);
    @(negedge clk);
    if (src == 0) home_n = 1'b0; else if (src == 1) sleep_n = 1'b0; else uvlo = 1'b1;
    @(negedge clk);
    chk("R9", "bridge_on in hold", bridge_on, 0);
    step_in = 1'b1; @(negedge clk); step_in = 1'b0; @(negedge clk);
    step_in = 1'b1;
    exp_pos = 4; exp_da = 1; exp_db = 1;
    chk_all("R8");
    @(negedge clk);
    home_n = 1'b1; sleep_n = 1'b1; uvlo = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R8");
    chk("R9", "bridge_on after hold", bridge_on, 1);
    step_in = 1'b0;
    @(negedge clk);
  endtask

  // R9 R10
  task automatic t_enable();
    @(negedge clk); en_n = 1'b1;
    @(negedge clk);
    chk("R9", "bridge_on disabled", bridge_on, 0);
    decay_sel = 2'b00;
    do_step(1'b1, 2'b10);
    chk_all("R10");
    do_step(1'b0, 2'b11);
    chk_all("R10");
    @(negedge clk); en_n = 1'b0;
    @(negedge clk);
    chk("R9", "bridge_on enabled", bridge_on, 1);
  endtask

  initial begin
    t_reset();
    t_sweep(1'b1, 2'b11, 2'b01);
    t_sweep(1'b0, 2'b11, 2'b10);
    t_sweep(1'b1, 2'b10, 2'b11);
    t_sweep(1'b0, 2'b01, 2'b00);
    t_sweep(1'b1, 2'b00, 2'b10);
    t_sweep(1'b0, 2'b00, 2'b11);
    t_mode_hold();
    t_align();
    t_hold(0);
    t_hold(1);
    t_hold(2);
    t_enable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule